// File: doc/BRIEF.md
# Write-Protection Command Sequencer

This block sits in front of a byte-wide nonvolatile memory's page-load controller and screens every qualified write (address plus data) before it reaches that controller. It recognises two fixed command sequences written to two key addresses: a three-write unlock sequence and a six-write disable sequence. It keeps a protection flag that outlives the ordinary reset and is cleared only by a separate factory-clear input.

While the flag is clear, ordinary writes go straight through one cycle later. The unlock sequence sets the flag, whether or not it was already set, and opens a load window for a single page of up to `PAGE_BYTES` writes. The window closes when the downstream controller reports that programming has finished, and the memory is then locked again. While the flag is set and no window is open, ordinary writes are dropped. The disable sequence clears the flag. Command writes are never forwarded. Any write that breaks a sequence aborts it.

Top module: `swp_sequencer`

## Requirements
- R1: After `rst_n` low with `factoryClr` high, `passValid` is 0, `windowOpen` is 0 and `protOn` is 0.
- R2: With `protOn` = 0 and no sequence in progress, a write that is not a command step appears on `passValid`/`passAddr`/`passData` exactly one clock after it is presented, with the same address and data.
- R3: The writes 0xAA to 0x1555, 0x55 to 0x0AAA and 0xA0 to 0x1555, in that order, set `protOn` and `windowOpen` one clock after the third write. None of the three is forwarded. This holds whether `protOn` was 0 or 1 beforehand.
- R4: With `protOn` = 1 and `windowOpen` = 0, an ordinary write is not forwarded.
- R5: While the window is open, the first `PAGE_BYTES` writes (64 by default) are forwarded with their own address and data. Any later write in the same window is dropped.
- R6: A `progDone` pulse while the window is open clears `windowOpen` one clock later and leaves `protOn` at 1.
- R7: The six writes 0xAA→0x1555, 0x55→0x0AAA, 0x80→0x1555, 0xAA→0x1555, 0x55→0x0AAA, 0x20→0x1555 clear `protOn` one clock after the sixth write. None of them is forwarded, and later ordinary writes pass.
- R8: A write that does not match the next expected step aborts the sequence. That write is forwarded if `protOn` = 0 and dropped if `protOn` = 1. A later 0xA0→0x1555 write then does not open a window.
- R9: `rst_n` does not change `protOn`. Only `factoryClr` clears it.
- R10: If `progDone` and a write arrive in the same cycle while the window is open, the window closes and the write is judged as outside the window, so it is dropped when protected.
- R11: A 0xAA→0x1555 write that breaks a sequence starts a new sequence as its first step. For example, AA, AA, 55, A0 unlocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of sequencer and output stage |
| factoryClr | input | 1 | Synchronous clear of the protection flag and the sequencer |
| wrValid | input | 1 | Qualified write strobe, one cycle per write |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data |
| progDone | input | 1 | Pulse from the page-load controller when programming ends |
| passValid | output | 1 | Forwarded write strobe |
| passAddr | output | ADDR_W | Forwarded write address |
| passData | output | DATA_W | Forwarded write data |
| protOn | output | 1 | Protection flag |
| windowOpen | output | 1 | Page-load window open after unlock |

## Verification
Two functions can fall in the same cycle: the end-of-programming pulse that closes the load window, and a new write that would otherwise be loaded into that window. The bench drives both on the same clock edge while protected, inside an open window that has already accepted bytes. It expects no forwarded write, a closed window and the flag still set. The bench also walks a full 64-byte window followed by a 65th byte, and sweeps ordinary writes over spread addresses with data computed from the loop index.

// File: rtl/swp_pkg.sv
package swp_pkg;
  localparam logic [7:0] CMD_KEY1   = 8'hAA;
  localparam logic [7:0] CMD_KEY2   = 8'h55;
  localparam logic [7:0] CMD_LOCK   = 8'hA0;
  localparam logic [7:0] CMD_ERASE  = 8'h80;
  localparam logic [7:0] CMD_UNPROT = 8'h20;

  typedef enum logic [2:0] {
    ST_IDLE, ST_K1, ST_K2, ST_E3, ST_E4, ST_E5, ST_LOAD
  } seqState_t;

  typedef struct packed {
    logic fwd;
    logic cntInc;
    logic cntClr;
    logic setProt;
    logic clrProt;
  } seqStrobe_t;
endpackage

// File: rtl/swp_seq_ctrl.sv
module swp_seq_ctrl
  import swp_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR_HI = 13'h1555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_LO = 13'h0AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              factoryClr,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              progDone,
  input  logic              protIn,
  input  logic              pageFull,
  output seqStrobe_t        strobe,
  output logic              windowOpen
);
  seqState_t state, nextState, evalState;
  logic atHi, atLo, isStart, matched;

  function automatic logic isCode(input logic [DATA_W-1:0] d, input logic [7:0] c);
    return d == DATA_W'(c);
  endfunction

  always_comb begin
    atHi      = (wrAddr == KEY_ADDR_HI);
    atLo      = (wrAddr == KEY_ADDR_LO);
    isStart   = atHi && isCode(wrData, CMD_KEY1);
    // completion of programming closes the window before the write is judged
    evalState = (state == ST_LOAD && progDone) ? ST_IDLE : state;
    nextState = evalState;
    strobe    = '0;
    matched   = 1'b0;
    if (wrValid && rst_n && !factoryClr) begin
      case (evalState)
        ST_IDLE: if (isStart) begin matched = 1'b1; nextState = ST_K1; end
        ST_K1:   if (atLo && isCode(wrData, CMD_KEY2)) begin matched = 1'b1; nextState = ST_K2; end
        ST_K2: begin
          if (atHi && isCode(wrData, CMD_LOCK)) begin
            matched = 1'b1; nextState = ST_LOAD;
            strobe.setProt = 1'b1; strobe.cntClr = 1'b1;
          end else if (atHi && isCode(wrData, CMD_ERASE)) begin
            matched = 1'b1; nextState = ST_E3;
          end
        end
        ST_E3:   if (isStart) begin matched = 1'b1; nextState = ST_E4; end
        ST_E4:   if (atLo && isCode(wrData, CMD_KEY2)) begin matched = 1'b1; nextState = ST_E5; end
        ST_E5: begin
          if (atHi && isCode(wrData, CMD_UNPROT)) begin
            matched = 1'b1; nextState = ST_IDLE; strobe.clrProt = 1'b1;
          end
        end
        default: ;
      endcase
      if (evalState == ST_LOAD) begin
        nextState     = ST_LOAD;
        strobe.fwd    = !pageFull;
        strobe.cntInc = !pageFull;
      end else if (!matched) begin
        if (isStart) nextState = ST_K1;
        else begin
          nextState  = ST_IDLE;
          strobe.fwd = !protIn;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || factoryClr) state <= ST_IDLE;
    else                      state <= nextState;
  end

  assign windowOpen = (state == ST_LOAD);

  // R6: an open window always implies the protection flag is set
  a_r6_load_protected: assert property (@(posedge clk) disable iff (!rst_n || factoryClr)
    (state == ST_LOAD) |-> protIn);
  // R7: the flag is only cleared from the last disable step
  a_r7_clear_from_e5: assert property (@(posedge clk) disable iff (!rst_n || factoryClr)
    strobe.clrProt |-> (state == ST_E5));
endmodule

// File: rtl/swp_datapath.sv
module swp_datapath
  import swp_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              factoryClr,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  seqStrobe_t        strobe,
  output logic              protFlag,
  output logic              pageFull,
  output logic              passValid,
  output logic [ADDR_W-1:0] passAddr,
  output logic [DATA_W-1:0] passData
);
  localparam int CNT_W = $clog2(PAGE_BYTES + 1);
  logic [CNT_W-1:0] loadCnt;

  // flag ignores rst_n on purpose
  always_ff @(posedge clk) begin
    if (factoryClr)          protFlag <= 1'b0;
    else if (strobe.clrProt) protFlag <= 1'b0;
    else if (strobe.setProt) protFlag <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              loadCnt <= '0;
    else if (strobe.cntClr)  loadCnt <= '0;
    else if (strobe.cntInc)  loadCnt <= loadCnt + 1'b1;
  end

  assign pageFull = (loadCnt == CNT_W'(PAGE_BYTES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      passValid <= 1'b0;
      passAddr  <= '0;
      passData  <= '0;
    end else begin
      passValid <= strobe.fwd;
      if (strobe.fwd) begin
        passAddr <= wrAddr;
        passData <= wrData;
      end
    end
  end

  // R2: nothing is forwarded without an incoming write
  a_r2_pass_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    passValid |-> $past(wrValid));
  // R5: the load count never passes the page size
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    loadCnt <= CNT_W'(PAGE_BYTES));
  // R9: the flag moves only on a strobe or factory clear
  a_r9_flag_holds: assert property (@(posedge clk) disable iff (factoryClr)
    (!strobe.setProt && !strobe.clrProt) |=> $stable(protFlag));
endmodule

// File: rtl/swp_sequencer.sv
module swp_sequencer
  import swp_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 64,
  parameter logic [ADDR_W-1:0] KEY_ADDR_HI = 13'h1555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_LO = 13'h0AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              factoryClr,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              progDone,
  output logic              passValid,
  output logic [ADDR_W-1:0] passAddr,
  output logic [DATA_W-1:0] passData,
  output logic              protOn,
  output logic              windowOpen
);
  seqStrobe_t strobe;
  logic pageFull;

  swp_seq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                 .KEY_ADDR_HI(KEY_ADDR_HI), .KEY_ADDR_LO(KEY_ADDR_LO)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .factoryClr(factoryClr), .wrValid(wrValid),
    .wrAddr(wrAddr), .wrData(wrData), .progDone(progDone), .protIn(protOn),
    .pageFull(pageFull), .strobe(strobe), .windowOpen(windowOpen));

  swp_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_dp (
    .clk(clk), .rst_n(rst_n), .factoryClr(factoryClr), .wrValid(wrValid),
    .wrAddr(wrAddr), .wrData(wrData), .strobe(strobe), .protFlag(protOn),
    .pageFull(pageFull), .passValid(passValid), .passAddr(passAddr), .passData(passData));

  // R3: window opens only with the flag set and with the command itself swallowed
  a_r3_unlock_quiet: assert property (@(posedge clk) disable iff (!rst_n || factoryClr)
    $rose(windowOpen) |-> (protOn && !passValid));
  // R4: locked and no window means nothing leaves on the next cycle
  a_r4_locked_drop: assert property (@(posedge clk) disable iff (!rst_n || factoryClr)
    (protOn && !windowOpen) |=> !passValid);
endmodule

// File: tb/swp_sequencer_tb.sv
module swp_sequencer_tb;
  localparam int AW = 13;
  localparam int DW = 8;
  localparam int PB = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0, factoryClr = 1'b1, wrValid = 1'b0, progDone = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic passValid, protOn, windowOpen;
  logic [AW-1:0] passAddr;
  logic [DW-1:0] passData;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  swp_sequencer u_dut (.clk(clk), .rst_n(rst_n), .factoryClr(factoryClr), .wrValid(wrValid),
    .wrAddr(wrAddr), .wrData(wrData), .progDone(progDone), .passValid(passValid),
    .passAddr(passAddr), .passData(passData), .protOn(protOn), .windowOpen(windowOpen));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one write; outputs sampled on the negedge after the capturing edge
  task automatic wr(input string tag, input int a, input int d, input bit expPass);
    @(negedge clk);
    wrValid = 1'b1; wrAddr = AW'(a); wrData = DW'(d);
    @(negedge clk);
    wrValid = 1'b0;
    check(tag, int'(passValid), int'(expPass));
    if (expPass) begin
      check(tag, int'(passAddr), a);
      check(tag, int'(passData), d);
    end
  endtask

  task automatic pulseDone();
    @(negedge clk); progDone = 1'b1;
    @(negedge clk); progDone = 1'b0;
  endtask

  task automatic unlock(input string tag);
    wr(tag, 'h1555, 'hAA, 0);
    wr(tag, 'h0AAA, 'h55, 0);
    wr(tag, 'h1555, 'hA0, 0);
  endtask

  initial begin
    #(5ns * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; factoryClr = 1'b0;
    @(negedge clk);
    check("R1 passValid", int'(passValid), 0);
    check("R1 windowOpen", int'(windowOpen), 0);
    check("R1 protOn", int'(protOn), 0);

    // R2 sweep of ordinary writes while unprotected
    for (int i = 0; i < 16; i++) wr("R2 open write", (i * 517) % 8192, (i * 37 + 1) % 256, 1);

    // R3 unlock from unprotected
    unlock("R3 cmd swallowed");
    check("R3 protOn", int'(protOn), 1);
    check("R3 windowOpen", int'(windowOpen), 1);

    // R5 full page then one extra
    for (int i = 0; i < PB; i++) wr("R5 page byte", 'h0400 + i, (i * 3) % 256, 1);
    wr("R5 byte past page", 'h0400 + PB, 'h5A, 0);

    // R6 programming done closes window
    pulseDone();
    check("R6 window closed", int'(windowOpen), 0);
    check("R6 still protected", int'(protOn), 1);

    // R4 locked drops
    for (int i = 0; i < 4; i++) wr("R4 locked drop", 'h0100 + i * 9, 'h10 + i, 0);

    // R9 ordinary reset leaves flag
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R9 flag after rst_n", int'(protOn), 1);
    check("R9 window after rst_n", int'(windowOpen), 0);

    // R8 protected abort
    wr("R8 step1", 'h1555, 'hAA, 0);
    wr("R8 step2", 'h0AAA, 'h55, 0);
    wr("R8 breaking write dropped", 'h0200, 'h12, 0);
    wr("R8 late lock dropped", 'h1555, 'hA0, 0);
    check("R8 no window", int'(windowOpen), 0);

    // R11 restart on repeated first key; R3 while already protected
    wr("R11 k1", 'h1555, 'hAA, 0);
    wr("R11 k1 again", 'h1555, 'hAA, 0);
    wr("R11 k2", 'h0AAA, 'h55, 0);
    wr("R11 lock", 'h1555, 'hA0, 0);
    check("R11 window opened", int'(windowOpen), 1);
    wr("R11 load a", 'h0800, 'h01, 1);
    wr("R11 load b", 'h0801, 'h02, 1);

    // R10 progDone and write in the same cycle
    @(negedge clk);
    progDone = 1'b1; wrValid = 1'b1; wrAddr = AW'('h0802); wrData = DW'('h33);
    @(negedge clk);
    progDone = 1'b0; wrValid = 1'b0;
    check("R10 collided write dropped", int'(passValid), 0);
    check("R10 window closed", int'(windowOpen), 0);
    check("R10 still protected", int'(protOn), 1);

    // R7 disable sequence
    wr("R7 d1", 'h1555, 'hAA, 0);
    wr("R7 d2", 'h0AAA, 'h55, 0);
    wr("R7 d3", 'h1555, 'h80, 0);
    wr("R7 d4", 'h1555, 'hAA, 0);
    wr("R7 d5", 'h0AAA, 'h55, 0);
    wr("R7 d6", 'h1555, 'h20, 0);
    check("R7 flag cleared", int'(protOn), 0);
    wr("R7 write passes", 'h0321, 'h9C, 1);

    // R8 unprotected abort forwards the breaking write
    wr("R8 open step1", 'h1555, 'hAA, 0);
    wr("R8 open breaking write", 'h0123, 'h77, 1);
    check("R8 open still clear", int'(protOn), 0);

    // R9 factory clear
    unlock("R9 relock");
    pulseDone();
    check("R9 flag set", int'(protOn), 1);
    @(negedge clk); factoryClr = 1'b1;
    @(negedge clk); factoryClr = 1'b0;
    @(negedge clk);
    check("R9 factory clear", int'(protOn), 0);
    wr("R9 write after clear", 'h0042, 'hE1, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule